// File: doc/BRIEF.md
# Two-Slot Instruction Prefetch Queue

This block is the fetch front end of a processor that runs either 32-bit instructions or 16-bit compressed instructions. It holds two fetched opcodes. The oldest one is presented for execution, and the program counter it keeps is always two instruction sizes past that opcode. When execution consumes the presented opcode, the queue shifts by one and a single bus fetch fills the free slot. When the consumed instruction redirects control flow, the queue is emptied and refilled from a new, aligned program counter.

The bus side is a simple request/ready port. Each access carries an address, a size (word or halfword) and a tag marking it sequential or non-sequential. A refill always starts with one non-sequential access, followed by one sequential access. Every later fetch in the same stream is sequential. Reset behaves like a refill from a parameterised start address, so the queue is full before the first opcode is issued. The instruction-set state is taken only when a redirect is accepted, and it stays fixed until the next redirect.

Top module: `prefetch_q2`

## Requirements
- R1: After reset the block requests a non-sequential fetch at RESET_PC. Bit 0 of that address is cleared, and bit 1 is also cleared unless RESET_HALF is set. The fetch size follows RESET_HALF, and issue_valid_o is low.
- R2: A refill makes exactly two bus accesses to consecutive addresses. The first has bus_seq_o=0 and the second has bus_seq_o=1. Every later fetch until the next refill has bus_seq_o=1.
- R3: While issue_valid_o is high, issue_op_o is the oldest fetched opcode not yet consumed. issue_pc_o equals pc_o minus two instruction sizes, and pc_o is the address of the next fetch.
- R4: A step with redirect_i low while issue_valid_o is high consumes the oldest opcode and moves the second opcode up. It then makes one fetch at pc_o, and issue_valid_o stays low until that fetch is accepted.
- R5: In 32-bit state (half_mode_o=0), fetches have bus_word_o=1 and pc_o advances by 4 per accepted access. In 16-bit state, fetches have bus_word_o=0, pc_o advances by 2, and the opcode is bus_rdata_i[15:0] zero-extended to 32 bits.
- R6: Fetch addresses are aligned. Bit 0 is always zero, and bit 1 is zero in 32-bit state. The redirect address is masked this way before the refill starts.
- R7: A step with redirect_i high while issue_valid_o is high discards both queued opcodes. It samples half_mode_i as the new state and refills from the masked redirect_pc_i.
- R8: half_mode_i has no effect on half_mode_o, fetch size or pc_o at any time other than an accepted redirect.
- R9: step_i and redirect_i are ignored while issue_valid_o is low.
- R10: While bus_req_o is high and bus_ready_i is low, bus_req_o stays high, and bus_addr_o, bus_word_o and bus_seq_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_mode_i | input | 1 | Instruction-set state to use after a redirect (1 = 16-bit) |
| step_i | input | 1 | Execution consumes the issued opcode |
| redirect_i | input | 1 | The consumed opcode redirects control flow; qualifies step_i |
| redirect_pc_i | input | AW | Target program counter for a redirect |
| issue_valid_o | output | 1 | Queue full, issue_op_o may be consumed |
| issue_op_o | output | IW | Oldest queued opcode |
| issue_pc_o | output | AW | Address of issue_op_o |
| pc_o | output | AW | Program counter, two instructions ahead of issue_pc_o |
| half_mode_o | output | 1 | Current instruction-set state (1 = 16-bit) |
| bus_req_o | output | 1 | Fetch request |
| bus_addr_o | output | AW | Fetch address |
| bus_word_o | output | 1 | 1 = word access, 0 = halfword access |
| bus_seq_o | output | 1 | 1 = sequential access, 0 = non-sequential |
| bus_rdata_i | input | IW | Fetched data, valid with bus_ready_i |
| bus_ready_i | input | 1 | Accepts the current request and delivers its data |

## Verification
The hardest case to reach from the ports is a step or redirect that arrives while a refill or a single fetch is stalled. In that case the block must ignore both, and it must also ignore half_mode_i as it toggles. The stimulus keeps step_i and redirect_i asserted over long stretches while bus_ready_i is low most of the time, and it flips half_mode_i every cycle. Because of this, each stalled fetch cycle also presents a would-be redirect and a mode change. A behavioural queue model then checks the address, the tags and the state cycle by cycle.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int NSLOT = 2;

  typedef enum logic [1:0] {
    ST_FILL0 = 2'd0,  // refill, first (non-sequential) access
    ST_FILL1 = 2'd1,  // refill, second access
    ST_NEXT  = 2'd2,  // single fetch after a step
    ST_RUN   = 2'd3   // queue full, opcode issued
  } fq_state_e;
endpackage

// File: rtl/fq_ctrl.sv
module fq_ctrl
  import fq_pkg::*;
#(
  parameter bit RESET_HALF = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic redir_i,
  input  logic half_mode_i,
  input  logic ready_i,
  output logic half_o,
  output logic valid_o,
  output logic req_o,
  output logic seq_o,
  output logic ld_o,
  output logic shift_o,
  output logic wr0_o,
  output logic wr1_o,
  output logic inc_o
);
  fq_state_e st_q, st_d;
  logic      half_q;
  logic      ack, take;

  assign req_o   = (st_q != ST_RUN);
  assign valid_o = (st_q == ST_RUN);
  assign seq_o   = (st_q != ST_FILL0);
  assign ack     = req_o & ready_i;
  assign take    = valid_o & step_i;
  assign ld_o    = take & redir_i;
  assign shift_o = take & ~redir_i;
  assign inc_o   = ack;
  assign wr0_o   = ack & (st_q == ST_FILL0);
  assign wr1_o   = ack & (st_q != ST_FILL0);
  assign half_o  = half_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FILL0: if (ack) st_d = ST_FILL1;
      ST_FILL1: if (ack) st_d = ST_RUN;
      ST_NEXT:  if (ack) st_d = ST_RUN;
      ST_RUN: begin
        if (ld_o)         st_d = ST_FILL0;
        else if (shift_o) st_d = ST_NEXT;
      end
      default:            st_d = ST_FILL0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FILL0;
      half_q <= RESET_HALF;
    end else begin
      st_q <= st_d;
      if (ld_o) half_q <= half_mode_i;
    end
  end

  AST_MODE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_o |=> half_q == $past(half_q)); // R8

  AST_REDIR_NONSEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> req_o && !seq_o); // R7
endmodule

// File: rtl/fq_pc.sv
module fq_pc #(
  parameter int               AW         = 32,
  parameter logic [AW-1:0]    RESET_PC   = '0,
  parameter bit               RESET_HALF = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          ld_half_i,
  input  logic [AW-1:0] ld_pc_i,
  input  logic          inc_i,
  input  logic          half_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] MASK_H   = ~AW'(1);
  localparam logic [AW-1:0] MASK_W   = ~AW'(3);
  localparam logic [AW-1:0] STEP_H   = AW'(2);
  localparam logic [AW-1:0] STEP_W   = AW'(4);
  localparam logic [AW-1:0] PC_RESET = RESET_PC & (RESET_HALF ? MASK_H : MASK_W);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= PC_RESET;
    else if (ld_i)  pc_q <= ld_pc_i & (ld_half_i ? MASK_H : MASK_W);
    else if (inc_i) pc_q <= pc_q + (half_i ? STEP_H : STEP_W);
  end

  assign pc_o = pc_q;

  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_q[0] && (half_i || !pc_q[1])); // R6
endmodule

// File: rtl/fq_slots.sv
module fq_slots
  import fq_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          wr0_i,
  input  logic          wr1_i,
  input  logic          half_i,
  input  logic [IW-1:0] wdata_i,
  output logic [IW-1:0] head_o
);
  localparam int HW = IW / 2;

  logic [IW-1:0] slot_q [NSLOT];
  logic [IW-1:0] wdat;

  // halfword fetch lands in the low half, upper half cleared
  assign wdat = half_i ? {{(IW-HW){1'b0}}, wdata_i[HW-1:0]} : wdata_i;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      slot_q[i] <= '0;
        else if (wr0_i)   slot_q[i] <= wdat;
        else if (shift_i) slot_q[i] <= slot_q[i+1];
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    slot_q[i] <= '0;
        else if (wr1_i) slot_q[i] <= wdat;
      end
    end
  end

  assign head_o = slot_q[0];

  AST_SHIFT_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> slot_q[0] == $past(slot_q[1])); // R4

  AST_HALF_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1_i && half_i |=> slot_q[1][IW-1:HW] == '0); // R5
endmodule

// File: rtl/prefetch_q2.sv
module prefetch_q2
  import fq_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            IW         = 32,
  parameter logic [AW-1:0] RESET_PC   = '0,
  parameter bit            RESET_HALF = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_mode_i,
  input  logic          step_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_pc_i,
  output logic          issue_valid_o,
  output logic [IW-1:0] issue_op_o,
  output logic [AW-1:0] issue_pc_o,
  output logic [AW-1:0] pc_o,
  output logic          half_mode_o,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_word_o,
  output logic          bus_seq_o,
  input  logic [IW-1:0] bus_rdata_i,
  input  logic          bus_ready_i
);
  localparam logic [AW-1:0] LAG_H = AW'(2 * NSLOT);
  localparam logic [AW-1:0] LAG_W = AW'(4 * NSLOT);

  logic          half, ld, shift, wr0, wr1, inc;
  logic [AW-1:0] pc;

  fq_ctrl #(.RESET_HALF(RESET_HALF)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .redir_i     (redirect_i),
    .half_mode_i (half_mode_i),
    .ready_i     (bus_ready_i),
    .half_o      (half),
    .valid_o     (issue_valid_o),
    .req_o       (bus_req_o),
    .seq_o       (bus_seq_o),
    .ld_o        (ld),
    .shift_o     (shift),
    .wr0_o       (wr0),
    .wr1_o       (wr1),
    .inc_o       (inc)
  );

  fq_pc #(.AW(AW), .RESET_PC(RESET_PC), .RESET_HALF(RESET_HALF)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld),
    .ld_half_i (half_mode_i),
    .ld_pc_i   (redirect_pc_i),
    .inc_i     (inc),
    .half_i    (half),
    .pc_o      (pc)
  );

  fq_slots #(.IW(IW)) u_slots (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .wr0_i   (wr0),
    .wr1_i   (wr1),
    .half_i  (half),
    .wdata_i (bus_rdata_i),
    .head_o  (issue_op_o)
  );

  assign pc_o        = pc;
  assign bus_addr_o  = pc;
  assign bus_word_o  = ~half;
  assign half_mode_o = half;
  assign issue_pc_o  = pc - (half ? LAG_H : LAG_W);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o)
      && $stable(bus_word_o) && $stable(bus_seq_o)); // R10

  AST_NONSEQ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_seq_o && bus_ready_i |=> bus_req_o && bus_seq_o); // R2

  AST_STEP_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && step_i && !redirect_i |=> bus_req_o && bus_seq_o && !issue_valid_o); // R4

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o && !bus_ready_i |=> $stable(pc_o) && $stable(half_mode_o)); // R9
endmodule

// File: tb/prefetch_q2_tb.sv
module prefetch_q2_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC     = 32'h0000_0103;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        half_mode_i = 1'b0, step_i = 1'b0, redirect_i = 1'b0, bus_ready_i = 1'b0;
  logic [31:0] redirect_pc_i = '0;
  logic        issue_valid_o, half_mode_o, bus_req_o, bus_word_o, bus_seq_o;
  logic [31:0] issue_op_o, issue_pc_o, pc_o, bus_addr_o, bus_rdata_i;

  int    n_chk = 0, n_bad = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  // reference model
  int          need;
  logic [31:0] m_pc;
  bit          m_half;
  logic [31:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h3C5A_A5C3 ^ {a[15:0], a[31:16]};
  endfunction

  assign bus_rdata_i = mem_word(bus_addr_o);

  prefetch_q2 #(.AW(32), .IW(32), .RESET_PC(RST_PC), .RESET_HALF(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .half_mode_i(half_mode_i), .step_i(step_i),
    .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i),
    .issue_valid_o(issue_valid_o), .issue_op_o(issue_op_o), .issue_pc_o(issue_pc_o),
    .pc_o(pc_o), .half_mode_o(half_mode_o), .bus_req_o(bus_req_o),
    .bus_addr_o(bus_addr_o), .bus_word_o(bus_word_o), .bus_seq_o(bus_seq_o),
    .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit rd, logic [31:0] rpc, bit th, bit rdy);
    logic [31:0] sz = m_half ? 32'd2 : 32'd4;
    bit          v  = (need == 0);
    chk("R4 issue_valid_o", {31'b0, issue_valid_o}, {31'b0, v});
    if (v) begin
      chk("R3 issue_op_o", issue_op_o, q[0]);
      chk("R3 issue_pc_o", issue_pc_o, m_pc - 2 * sz);
    end
    chk("R2 bus_req_o", {31'b0, bus_req_o}, {31'b0, need > 0});
    if (need > 0) begin
      chk("R6 bus_addr_o", bus_addr_o, m_pc);
      chk("R5 bus_word_o", {31'b0, bus_word_o}, {31'b0, !m_half});
      chk("R2 bus_seq_o", {31'b0, bus_seq_o}, {31'b0, need != 2});
    end
    chk("R8 half_mode_o", {31'b0, half_mode_o}, {31'b0, m_half});
    chk("R3 pc_o", pc_o, m_pc);
    step_i = st; redirect_i = rd; redirect_pc_i = rpc; half_mode_i = th; bus_ready_i = rdy;
    if (need > 0) begin
      if (rdy) begin
        q.push_back(m_half ? (mem_word(m_pc) & 32'h0000_FFFF) : mem_word(m_pc));
        m_pc += sz;
        need--;
      end
    end else if (st) begin
      if (rd) begin
        q.delete();
        m_half = th;
        m_pc   = rpc & (th ? ~32'd1 : ~32'd3);
        need   = 2;
      end else begin
        void'(q.pop_front());
        need = 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic run(string ph, int n, int p_rdy, int p_st, int p_rd, int th_mode);
    phase = ph;
    for (int i = 0; i < n; i++) begin
      bit th;
      case (th_mode)
        0: th = 1'b0;
        1: th = 1'b1;
        2: th = i[0];
        default: th = 1'($urandom_range(0, 1));
      endcase
      cyc($urandom_range(0, 99) < p_st, $urandom_range(0, 99) < p_rd,
          $urandom(), th, $urandom_range(0, 99) < p_rdy);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    need = 2; m_pc = RST_PC & ~32'd3; m_half = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state, refill stalled twice
    cyc(1, 1, 32'h55, 1, 0);
    cyc(1, 0, 32'h0, 1, 0);
    run("R2 refill", 3, 100, 0, 0, 0);
    run("R3 issue stream", 40, 100, 100, 0, 0);
    run("R10 stall", 200, 30, 50, 0, 0);
    run("R7 redirect", 400, 70, 60, 40, 3);
    run("R8 mode noise", 300, 60, 70, 5, 2);
    run("R9 step while busy", 300, 15, 100, 50, 2);
    phase = "R5 16-bit";
    while (need > 0) cyc(0, 0, 0, 0, 1);
    cyc(1, 1, 32'h0000_2003, 1, 1);
    run("R5 16-bit", 200, 80, 60, 0, 0);
    run("R6 align", 300, 70, 70, 50, 3);
    finish_up();
  end
endmodule